// File: doc/BRIEF.md
# Host Register Port with Command Decoder

This block is an 8-bit register port that an external processor reaches over an asynchronous parallel bus. The bus has an active-low select, an active-low read strobe and an active-low write strobe. It also has a 4-bit register address input and an 8-bit data bus, which is split here into an input, an output and an output enable. Every bus input except the read strobe passes through a two-flop synchroniser. Edges are then detected in the core clock domain.

The register index is taken once per select period, at the moment the select line falls. A static mode pin sets where the index comes from. With the pin low, the index comes from the address pins and the data bus carries only data. With the pin high, the low nibble of the data bus carries the index at the select edge, and the bus then carries data for the rest of the period.

The port holds sixteen byte-wide registers:
- Index 3 is a command register. A code it does not recognise sets a sticky interrupt.
- Code 0x01 is a software reset. It clears the interrupt and every register.
- Index 2 is a read-only status byte that reports the interrupt.

Top module: `hostRegPort`

## Requirements
- R1: After hardware reset (rstN low), all sixteen indices read 0x00, irq is low and dataOe is low.
- R2: dataOe is high only while csN and rdN are both low. While dataOe is high, dataOut shows the register at the latched index.
- R3: With muxMode low, the index is the value of addrIn at the falling edge of csN.
- R4: With muxMode high, the index is dataIn[3:0] at the falling edge of csN. dataIn[7:4] and addrIn have no effect on the index.
- R5: The index changes only on a csN falling edge. Address changes later in the same select period are ignored.
- R6: A write commits dataIn to the latched index on the rising edge of wrN while csN is low. A wrN pulse with csN high changes nothing.
- R7: Every index other than 2 and 3 stores the last byte written to it and reads it back.
- R8: At index 3, code 0x00 is a no-op and code 0x01 is a software reset. Any other code sets the interrupt flag, which drives irq high. Index 3 reads back the last code written.
- R9: Once set, the interrupt flag stays high through further illegal codes and no-ops. Only a software reset or a hardware reset clears it.
- R10: A software reset clears the interrupt flag and returns all sixteen indices to 0x00.
- R11: Index 2 is read-only. Bit 0 equals the interrupt flag, bits 7:1 read 0, and writes to index 2 are ignored.
- R12: A hardware reset in the middle of operation clears stored registers and the interrupt flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| csN | input | 1 | Active-low select |
| rdN | input | 1 | Active-low read strobe |
| wrN | input | 1 | Active-low write strobe |
| muxMode | input | 1 | 1: index taken from data bus; 0: from addrIn |
| addrIn | input | 4 | Register address pins |
| dataIn | input | 8 | Data bus, inbound half |
| dataOut | output | 8 | Data bus, outbound half |
| dataOe | output | 1 | Data bus output enable |
| irq | output | 1 | Sticky interrupt for illegal commands |

## Verification
The bench builds the port with its default sixteen-entry, byte-wide configuration. At that size, every index can be written and read back in both addressing modes. All 256 command codes can also be swept, each with its own interrupt and software-reset cycle. In multiplexed mode the bench puts noise on the upper data nibble and on addrIn. It also moves addrIn after the select edge, which makes the ignored bits and the once-per-select capture visible at dataOut.

// File: rtl/hrp_pkg.sv
package hrp_pkg;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 4;
  localparam int NUM_REGS = 1 << ADDR_W;
  localparam int STAT_IDX = 2;
  localparam int CMD_IDX  = 3;
  localparam logic [DATA_W-1:0] CMD_NOP      = 8'h00;
  localparam logic [DATA_W-1:0] CMD_SOFT_RST = 8'h01;
  localparam int SYNC_W   = 3 + ADDR_W + DATA_W;

  typedef struct packed {
    logic              capture;
    logic              wrEn;
    logic [ADDR_W-1:0] idx;
    logic [DATA_W-1:0] wrData;
  } hrpStrobe_t;
endpackage

// File: rtl/hrp_sync.sv
module hrp_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= RST_VAL;
      dout   <= RST_VAL;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end
endmodule

// File: rtl/hrp_ctrl.sv
module hrp_ctrl
  import hrp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              csS,
  input  logic              wrS,
  input  logic              muxS,
  input  logic [ADDR_W-1:0] addrS,
  input  logic [DATA_W-1:0] dataS,
  output hrpStrobe_t        strb
);
  logic              csPrev;
  logic              wrPrev;
  logic [ADDR_W-1:0] idxQ;
  logic [ADDR_W-1:0] nextIdx;
  logic              capture;
  logic              wrEn;

  assign capture = csPrev & ~csS;
  assign wrEn    = ~wrPrev & wrS & ~csS;

  generate
    if (ADDR_W <= DATA_W) begin : g_idxSel
      assign nextIdx = muxS ? dataS[ADDR_W-1:0] : addrS;
    end else begin : g_idxWide
      assign nextIdx = muxS ? ADDR_W'(dataS) : addrS;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPrev <= 1'b1;
      wrPrev <= 1'b1;
      idxQ   <= '0;
    end else begin
      csPrev <= csS;
      wrPrev <= wrS;
      if (capture) idxQ <= nextIdx;
    end
  end

  always_comb begin
    strb.capture = capture;
    strb.wrEn    = wrEn;
    strb.idx     = idxQ;
    strb.wrData  = dataS;
  end
endmodule

// File: rtl/hrp_datapath.sv
module hrp_datapath
  import hrp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  hrpStrobe_t        strb,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  logic [DATA_W-1:0] regVal [NUM_REGS];
  logic irqQ;
  logic cmdWr;
  logic softRst;
  logic illegalCmd;

  assign cmdWr      = strb.wrEn && (strb.idx == ADDR_W'(CMD_IDX));
  assign softRst    = cmdWr && (strb.wrData == CMD_SOFT_RST);
  assign illegalCmd = cmdWr && (strb.wrData != CMD_NOP) && (strb.wrData != CMD_SOFT_RST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          irqQ <= 1'b0;
    else if (softRst)   irqQ <= 1'b0;
    else if (illegalCmd) irqQ <= 1'b1;
  end

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      if (g == STAT_IDX) begin : g_stat
        assign regVal[g] = {{(DATA_W-1){1'b0}}, irqQ};
      end else begin : g_store
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN)                                          q <= '0;
          else if (softRst)                                   q <= '0;
          else if (strb.wrEn && strb.idx == ADDR_W'(g))       q <= strb.wrData;
        end
        assign regVal[g] = q;
      end
    end
  endgenerate

  assign rdData = regVal[strb.idx];
  assign irq    = irqQ;
endmodule

// File: rtl/hostRegPort.sv
module hostRegPort
  import hrp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic              muxMode,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              irq
);
  localparam logic [SYNC_W-1:0] SYNC_RST = {2'b11, {(SYNC_W-2){1'b0}}};

  logic [SYNC_W-1:0] rawBus;
  logic [SYNC_W-1:0] syncBus;
  logic              csS, wrS, muxS;
  logic [ADDR_W-1:0] addrS;
  logic [DATA_W-1:0] dataS;
  hrpStrobe_t        strb;
  logic [DATA_W-1:0] rdData;

  assign rawBus = {csN, wrN, muxMode, addrIn, dataIn};

  hrp_sync #(.W(SYNC_W), .RST_VAL(SYNC_RST)) u_sync (
    .clk (clk), .rstN(rstN), .din(rawBus), .dout(syncBus)
  );

  assign {csS, wrS, muxS, addrS, dataS} = syncBus;

  hrp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .csS(csS), .wrS(wrS), .muxS(muxS),
    .addrS(addrS), .dataS(dataS), .strb(strb)
  );

  hrp_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rdData(rdData), .irq(irq)
  );

  assign dataOe  = ~csN & ~rdN;
  assign dataOut = rdData;
endmodule

// File: rtl/hrp_checker.sv
module hrp_checker
  import hrp_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       csN,
  input logic       dataOe,
  input logic       irq,
  input hrpStrobe_t strb
);
  logic cmdWrC;
  logic softC;
  logic badC;
  assign cmdWrC = strb.wrEn && (strb.idx == ADDR_W'(CMD_IDX));
  assign softC  = cmdWrC && (strb.wrData == CMD_SOFT_RST);
  assign badC   = cmdWrC && (strb.wrData != CMD_NOP) && (strb.wrData != CMD_SOFT_RST);

  AST_OE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> !csN) else $error("oe without select"); // R2

  AST_IDX_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> $stable(strb.idx)) else $error("index moved"); // R5

  AST_ILLEGAL_RAISES: assert property (@(posedge clk) disable iff (!rstN)
    badC |=> irq) else $error("illegal code no irq"); // R8

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !softC) |=> irq) else $error("irq dropped"); // R9

  AST_SOFT_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    softC |=> !irq) else $error("soft reset kept irq"); // R10
endmodule

bind hostRegPort hrp_checker u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .dataOe(dataOe), .irq(irq), .strb(strb)
);

// File: tb/hostRegPort_bench.sv
module hostRegPort_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, rdN = 1'b1, wrN = 1'b1, muxMode = 1'b0;
  logic [3:0] addrIn = '0;
  logic [7:0] dataIn = '0;
  logic [7:0] dataOut;
  logic dataOe, irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [7:0] model [NREG];
  bit modelIrq;

  always #(CLK_PERIOD/2) clk = ~clk;

  hostRegPort u_hostRegPort (
    .clk(clk), .rstN(rstN), .csN(csN), .rdN(rdN), .wrN(wrN),
    .muxMode(muxMode), .addrIn(addrIn), .dataIn(dataIn),
    .dataOut(dataOut), .dataOe(dataOe), .irq(irq)
  );

  task automatic ticks(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clearModel();
    for (int i = 0; i < NREG; i++) model[i] = 8'h00;
    modelIrq = 0;
  endtask

  function automatic logic [7:0] expRead(int idx);
    if (idx == 2) return {7'b0, modelIrq};
    return model[idx];
  endfunction

  task automatic modelWrite(int idx, logic [7:0] val);
    if (idx == 3) begin
      if (val == 8'h01) begin
        clearModel();
      end else begin
        model[3] = val;
        if (val != 8'h00) modelIrq = 1;
      end
    end else if (idx != 2) begin
      model[idx] = val;
    end
  endtask

  // start a select period; disturb moves the address after capture
  task automatic selectStart(bit mux, int idx, logic [3:0] junk);
    if (mux) begin
      dataIn = {junk, 4'(idx)};
      addrIn = ~4'(idx);
    end else begin
      addrIn = 4'(idx);
      dataIn = {junk, ~4'(idx)};
    end
    ticks(1);
    csN = 1'b0;
    ticks(5);
  endtask

  task automatic busWrite(bit mux, int idx, logic [7:0] val, bit disturb);
    selectStart(mux, idx, 4'hA);
    if (disturb) addrIn = addrIn + 4'd1;
    dataIn = val;
    ticks(1);
    wrN = 1'b0;
    ticks(4);
    wrN = 1'b1;
    ticks(4);
    csN = 1'b1;
    ticks(3);
    modelWrite(idx, val);
  endtask

  task automatic busRead(bit mux, int idx, string req);
    selectStart(mux, idx, 4'h5);
    dataIn = 8'h00;
    check("R2 oe low before read strobe", {7'b0, dataOe}, 8'h00);
    rdN = 1'b0;
    ticks(1);
    check("R2 oe during read", {7'b0, dataOe}, 8'h01);
    check(req, dataOut, expRead(idx));
    rdN = 1'b1;
    ticks(1);
    csN = 1'b1;
    ticks(3);
  endtask

  task automatic checkIrq(string req);
    check(req, {7'b0, irq}, {7'b0, modelIrq});
  endtask

  initial begin
    clearModel();
    ticks(4);
    rstN = 1'b1;
    ticks(2);
    // R1 reset state
    check("R1 oe after reset", {7'b0, dataOe}, 8'h00);
    checkIrq("R1 irq after reset");
    for (int i = 0; i < NREG; i++) busRead(0, i, "R1 register after reset");

    // R3 / R7 non-multiplexed sweep
    muxMode = 1'b0; ticks(3);
    for (int i = 0; i < NREG; i++)
      if (i != 2 && i != 3) busWrite(0, i, 8'((i * 37) ^ 8'h5C), 0);
    for (int i = 0; i < NREG; i++) busRead(0, i, "R3 R7 direct-address readback");

    // R4 multiplexed sweep with noisy upper nibble
    muxMode = 1'b1; ticks(3);
    for (int i = 0; i < NREG; i++)
      if (i != 2 && i != 3) busWrite(1, i, 8'((i * 11) + 8'h81), 0);
    for (int i = 0; i < NREG; i++) busRead(1, i, "R4 multiplexed readback");
    muxMode = 1'b0; ticks(3);

    // R5 address moved after select edge
    busWrite(0, 6, 8'hC3, 1);
    busRead(0, 6, "R5 index held through select");
    busRead(0, 7, "R5 neighbour untouched");

    // R6 write strobe with select high
    addrIn = 4'd6; dataIn = 8'h3E; ticks(3);
    wrN = 1'b0; ticks(4); wrN = 1'b1; ticks(4);
    busRead(0, 6, "R6 write without select ignored");

    // R11 status read-only
    busWrite(0, 2, 8'hFF, 0);
    busRead(0, 2, "R11 status write ignored");

    // R10 soft reset clears stored data
    busWrite(0, 3, 8'h01, 0);
    for (int i = 0; i < NREG; i++) busRead(0, i, "R10 soft reset clears");

    // R8 / R9 / R10 sweep all command codes
    for (int c = 0; c < 256; c++) begin
      busWrite(0, 9, 8'(c ^ 8'h66), 0);
      busWrite(0, 3, 8'(c), 0);
      checkIrq("R8 irq after code");
      busRead(0, 3, "R8 command readback");
      busRead(0, 2, "R11 status mirrors irq");
      if (modelIrq) begin
        busWrite(0, 3, 8'h00, 0);
        checkIrq("R9 nop keeps irq");
        busWrite(0, 3, 8'hEE, 0);
        checkIrq("R9 illegal keeps irq");
        busWrite(0, 3, 8'h01, 0);
        checkIrq("R10 soft reset clears irq");
        busRead(0, 9, "R10 scratch cleared");
      end
    end

    // R12 hardware reset mid-operation
    busWrite(0, 12, 8'h9D, 0);
    busWrite(0, 3, 8'h42, 0);
    checkIrq("R12 irq set before reset");
    rstN = 1'b0; ticks(3); rstN = 1'b1; ticks(2);
    clearModel();
    checkIrq("R12 irq cleared by hw reset");
    busRead(0, 12, "R12 scratch cleared");
    busRead(0, 3, "R12 command cleared");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule